// File: doc/BRIEF.md
# One-Pulse PWM Timer

An up-counting timer that produces one pulse on a single PWM channel and then stops by itself. The count can be started in two ways. A rising edge on the external trigger input starts it. A one-cycle software set strobe also starts it. Once running, the counter steps once per clock from its present value up to the auto-reload value. On the next clock it wraps to zero. At that wrap the run bit drops, the counter halts, and a one-cycle update strobe is raised. A software clear strobe stops the count at once and freezes the counter value.

The reference output is a PWM level formed by comparing the counter with a compare value. Mode 0 drives the output high while the counter is below the compare value. Mode 1 drives it high at and above the compare value. Both modes drive it low whenever the timer is stopped. This comparison passes through a fixed register pipeline of a few clocks before it reaches the output. When the fast-compare option is set and the trigger starts the pulse, the output jumps to its post-match level on the very next cycle. It holds that level until the delayed comparison catches up.

Top module: `opm_pwm_timer`

## Requirements
- R1: After reset the counter reads 0, the run bit is 0, the update flag is 0 and the reference output is 0.
- R2: While stopped, a rising edge on `trigIn` (low in one sampled cycle, high in the next) sets the run bit at that clock edge with the counter unchanged. A trigger held high produces only one start.
- R3: While stopped, `swEnSet` high at a clock edge sets the run bit at that edge with the counter unchanged.
- R4: While running, the counter increments by one per clock. The edge at which it equals `reloadVal` loads 0 into it and clears the run bit. While stopped it holds its value.
- R5: `updFlag` is high for exactly the one cycle that follows the wrap edge, when the counter reads 0 and the run bit is 0.
- R6: `swEnClr` high at a clock edge clears the run bit and leaves the counter unchanged. It overrides a start and a wrap in the same cycle. A later start resumes counting from the held value.
- R7: While running, trigger edges and `swEnSet` have no effect on the counter or the run bit.
- R8: The undelayed level is run bit AND (counter < `cmpVal` when `pwmMode`=0, counter >= `cmpVal` when `pwmMode`=1). Without fast-compare, `refOut` shows this level `PIPE_STAGES` clocks later (default 2). It shows 0 for the first `PIPE_STAGES` cycles after reset.
- R9: A trigger-edge start with `fastEn`=1 forces `refOut` to the post-match level (0 in mode 0, 1 in mode 1) from the cycle after the start edge. The force holds until the delayed level of R8 equals that level or the run bit is 0 at a clock edge.
- R10: A start by `swEnSet` alone never applies the fast-compare force, whatever `fastEn` is.
- R11: A trigger edge and `swEnSet` in the same cycle while stopped count as a trigger start, so R9 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rstN | input | 1 | Active-low asynchronous reset |
| trigIn | input | 1 | External trigger, rising edge starts a pulse |
| swEnSet | input | 1 | Software start strobe |
| swEnClr | input | 1 | Software stop strobe |
| cmpVal | input | CNT_W | Compare value |
| reloadVal | input | CNT_W | Auto-reload value, last count before wrap |
| pwmMode | input | 1 | 0: active below compare, 1: active at or above compare |
| fastEn | input | 1 | Fast-compare enable for trigger starts |
| refOut | output | 1 | Reference PWM output |
| cntVal | output | CNT_W | Counter value |
| enOut | output | 1 | Run bit |
| updFlag | output | 1 | One-cycle update strobe after wrap |

## Verification
The main function is driven by software starts and by trigger starts in both PWM modes. This separates the start path from the output polarity. A long pulse with compare 4 and reload 0x60 sits beside short pulses at compare 0, compare above reload and reload 0. These tell apart the off-by-one cases in the compare and in the wrap. Fast-compare is tried with trigger starts, software starts and coincident starts in both modes, which shows whether the force is tied to the start source. Stops mid-pulse, stops coinciding with the wrap, held triggers and retriggers while running show the priorities between start, stop and update.

// File: rtl/opm_timer_pkg.sv
package opm_timer_pkg;

  // Output polarity selection
  typedef enum logic {
    MODE_ACTIVE_BELOW = 1'b0,
    MODE_ACTIVE_ABOVE = 1'b1
  } pwm_mode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic running;   // run bit as registered
    logic advance;   // counter steps this edge
    logic wrapNow;   // counter reloads to zero this edge
    logic fastArm;   // arm the fast-compare force this edge
  } ctl_strobe_t;

endpackage

// File: rtl/opm_timer_ctrl.sv
module opm_timer_ctrl
  import opm_timer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        trigIn,
  input  logic        swEnSet,
  input  logic        swEnClr,
  input  logic        fastEn,
  input  logic        atReload,
  output logic        runQ,
  output logic        updQ,
  output ctl_strobe_t strobes
);

  logic trigPrev;
  logic trigEdge;
  logic startReq;
  logic wrapNow;
  logic runNext;

  assign trigEdge = trigIn & ~trigPrev;
  // start only from the stopped state; clear wins over any start
  assign startReq = ~runQ & ~swEnClr & (trigEdge | swEnSet);
  assign wrapNow  = runQ & ~swEnClr & atReload;

  always_comb begin
    runNext = runQ;
    if (swEnClr)       runNext = 1'b0;
    else if (wrapNow)  runNext = 1'b0;
    else if (startReq) runNext = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigPrev <= 1'b0;
      runQ     <= 1'b0;
      updQ     <= 1'b0;
    end else begin
      trigPrev <= trigIn;
      runQ     <= runNext;
      updQ     <= wrapNow;
    end
  end

  always_comb begin
    strobes.running = runQ;
    strobes.advance = runQ & ~swEnClr;
    strobes.wrapNow = wrapNow;
    // a trigger edge in the start cycle marks a trigger start, even with swEnSet
    strobes.fastArm = ~runQ & ~swEnClr & trigEdge & fastEn;
  end

endmodule

// File: rtl/opm_timer_dpath.sv
module opm_timer_dpath
  import opm_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PIPE_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctl_strobe_t      strobes,
  input  logic [CNT_W-1:0] cmpVal,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic             pwmMode,
  output logic [CNT_W-1:0] cntQ,
  output logic             atReload,
  output logic             refOut
);

  localparam int LAST = PIPE_STAGES - 1;

  logic             levelNow;
  logic [LAST:0]    stageQ;
  logic             delayedLvl;
  logic             postLvl;
  logic             fastHold;
  pwm_mode_e        modeSel;

  assign modeSel  = pwm_mode_e'(pwmMode);
  assign atReload = (cntQ == reloadVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strobes.advance) begin
      if (strobes.wrapNow) cntQ <= '0;
      else                 cntQ <= cntQ + CNT_W'(1);
    end
  end

  always_comb begin
    if (modeSel == MODE_ACTIVE_ABOVE) levelNow = strobes.running & (cntQ >= cmpVal);
    else                              levelNow = strobes.running & (cntQ <  cmpVal);
  end

  // fixed-latency compare pipeline
  genvar gi;
  generate
    for (gi = 0; gi < PIPE_STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_head
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[0] <= 1'b0;
          else       stageQ[0] <= levelNow;
        end
      end else begin : g_tail
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[gi] <= 1'b0;
          else       stageQ[gi] <= stageQ[gi-1];
        end
      end
    end
  endgenerate

  assign delayedLvl = stageQ[LAST];
  assign postLvl    = (modeSel == MODE_ACTIVE_ABOVE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fastHold <= 1'b0;
    end else if (strobes.fastArm) begin
      fastHold <= 1'b1;
    end else if (!strobes.running) begin
      fastHold <= 1'b0;
    end else if (delayedLvl == postLvl) begin
      fastHold <= 1'b0;
    end
  end

  assign refOut = fastHold ? postLvl : delayedLvl;

endmodule

// File: rtl/opm_pwm_timer.sv
module opm_pwm_timer
  import opm_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PIPE_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigIn,
  input  logic             swEnSet,
  input  logic             swEnClr,
  input  logic [CNT_W-1:0] cmpVal,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic             pwmMode,
  input  logic             fastEn,
  output logic             refOut,
  output logic [CNT_W-1:0] cntVal,
  output logic             enOut,
  output logic             updFlag
);

  ctl_strobe_t strobes;
  logic        atReload;

  opm_timer_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .trigIn   (trigIn),
    .swEnSet  (swEnSet),
    .swEnClr  (swEnClr),
    .fastEn   (fastEn),
    .atReload (atReload),
    .runQ     (enOut),
    .updQ     (updFlag),
    .strobes  (strobes)
  );

  opm_timer_dpath #(
    .CNT_W       (CNT_W),
    .PIPE_STAGES (PIPE_STAGES)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .cmpVal    (cmpVal),
    .reloadVal (reloadVal),
    .pwmMode   (pwmMode),
    .cntQ      (cntVal),
    .atReload  (atReload),
    .refOut    (refOut)
  );

endmodule

// File: rtl/opm_pwm_timer_chk.sv
module opm_pwm_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             trigIn,
  input logic             swEnSet,
  input logic             swEnClr,
  input logic [CNT_W-1:0] cmpVal,
  input logic [CNT_W-1:0] reloadVal,
  input logic             pwmMode,
  input logic             fastEn,
  input logic             refOut,
  input logic [CNT_W-1:0] cntVal,
  input logic             enOut,
  input logic             updFlag
);

  logic trigSeen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) trigSeen <= 1'b0;
    else       trigSeen <= trigIn;
  end

  p_upd_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    updFlag |=> !updFlag);

  p_upd_at_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    updFlag |-> (cntVal == '0) && !enOut);

  p_hold_stopped_r4: assert property (@(posedge clk) disable iff (!rstN)
    !enOut |=> $stable(cntVal));

  p_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (enOut && !swEnClr && cntVal != reloadVal) |=> cntVal == $past(cntVal) + CNT_W'(1));

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (enOut && !swEnClr && cntVal == reloadVal) |=> (cntVal == '0) && !enOut && updFlag);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    swEnClr |=> !enOut && $stable(cntVal));

  p_fast_force_r9: assert property (@(posedge clk) disable iff (!rstN)
    (fastEn && pwmMode && !enOut && !swEnClr && trigIn && !trigSeen) |=> refOut && enOut);

  p_no_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    (enOut && !swEnClr && cntVal != reloadVal) |=> enOut);

  p_ref_known_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$isunknown({refOut, enOut, updFlag, cmpVal, swEnSet}));

endmodule

bind opm_pwm_timer opm_pwm_timer_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_opm_pwm_timer.sv
`timescale 1ns/1ps
module tb_opm_pwm_timer;

  localparam int CNT_W = 16;
  localparam int PIPE  = 2;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             trigIn = 1'b0, swEnSet = 1'b0, swEnClr = 1'b0;
  logic [CNT_W-1:0] cmpVal = '0, reloadVal = '0;
  logic             pwmMode = 1'b0, fastEn = 1'b0;
  logic             refOut, enOut, updFlag;
  logic [CNT_W-1:0] cntVal;

  always #2 clk = ~clk;  // 250 MHz

  opm_pwm_timer #(.CNT_W(CNT_W), .PIPE_STAGES(PIPE)) dut (.*);

  int nChecks = 0, nFails = 0;
  bit done = 0;

  // configuration applied at the next drive point
  int cfgCmp = 4, cfgReload = 'h60, cfgMode = 0, cfgFast = 0;

  // behavioural reference state
  int  mCnt = 0, mEn = 0, mUpd = 0, mTrigPrev = 0, mFast = 0;
  int  lvlQ[$];

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int expRef();
    return mFast ? cfgMode : lvlQ[0];
  endfunction

  task automatic compareAll();
    chk("R4 counter", int'(cntVal), mCnt);
    chk("R2 run bit", int'(enOut), mEn);
    chk("R5 update flag", int'(updFlag), mUpd);
    chk("R8 refOut", int'(refOut), expRef());
  endtask

  task automatic modelStep(int trig, int set, int clr);
    int edgeT, lvl, nEn, nCnt, nUpd, nFast;
    edgeT = trig && !mTrigPrev;
    if (!mEn) lvl = 0;
    else if (cfgMode == 1) lvl = (mCnt >= cfgCmp);
    else lvl = (mCnt < cfgCmp);
    nUpd = mEn && !clr && (mCnt == cfgReload);
    if (clr) nEn = 0;
    else if (mEn && mCnt == cfgReload) nEn = 0;
    else if (!mEn && (edgeT || set)) nEn = 1;
    else nEn = mEn;
    if (mEn && !clr) nCnt = (mCnt == cfgReload) ? 0 : mCnt + 1;
    else nCnt = mCnt;
    if (!mEn && !clr && edgeT && cfgFast) nFast = 1;
    else if (!mEn) nFast = 0;
    else if (lvlQ[0] == cfgMode) nFast = 0;
    else nFast = mFast;
    lvlQ.push_back(lvl);
    void'(lvlQ.pop_front());
    mEn = nEn; mCnt = nCnt; mUpd = nUpd; mFast = nFast; mTrigPrev = trig;
  endtask

  // one clock: drive at negedge, reference steps, compare after the edge
  task automatic tick(int trig, int set, int clr);
    @(negedge clk);
    trigIn = trig[0]; swEnSet = set[0]; swEnClr = clr[0];
    cmpVal = CNT_W'(cfgCmp); reloadVal = CNT_W'(cfgReload);
    pwmMode = cfgMode[0]; fastEn = cfgFast[0];
    modelStep(trig, set, clr);
    @(posedge clk); #1;
    compareAll();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0);
  endtask

  task automatic runOut();
    for (int i = 0; i < 200 && (enOut || mEn); i++) tick(0, 0, 0);
    idle(PIPE + 2);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stim
    int held;
    for (int i = 0; i < PIPE; i++) lvlQ.push_back(0);
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #0;
    // R1 reset state
    chk("R1 counter", int'(cntVal), 0);
    chk("R1 run bit", int'(enOut), 0);
    chk("R1 update", int'(updFlag), 0);
    chk("R1 refOut", int'(refOut), 0);
    idle(3);

    // R3 software start, mode 0, cmp 4, reload 0x60
    cfgCmp = 4; cfgReload = 'h60; cfgMode = 0; cfgFast = 0;
    tick(0, 1, 0);
    chk("R3 run after set", int'(enOut), 1);
    chk("R3 counter unchanged", int'(cntVal), 0);
    runOut();
    chk("R4 stopped at zero", int'(cntVal), 0);

    // R2 trigger held high, mode 1: one pulse only
    cfgMode = 1;
    tick(1, 0, 0);
    chk("R2 trigger start", int'(enOut), 1);
    for (int i = 0; i < 120; i++) tick(1, 0, 0);
    chk("R2 no restart with held trigger", int'(enOut), 0);
    tick(0, 0, 0); idle(PIPE + 2);

    // R7 retrigger and set while running
    cfgCmp = 3; cfgReload = 10; cfgMode = 0;
    tick(1, 0, 0); tick(0, 0, 0); tick(0, 0, 0);
    tick(1, 1, 0);
    chk("R7 counter unaffected", int'(cntVal), 3);
    chk("R7 run unaffected", int'(enOut), 1);
    runOut();

    // R6 stop mid-pulse, hold, resume
    tick(0, 1, 0); idle(5);
    tick(0, 0, 1);
    held = int'(cntVal);
    chk("R6 run cleared", int'(enOut), 0);
    idle(4);
    chk("R6 counter held", int'(cntVal), held);
    tick(0, 1, 0); tick(0, 0, 0);
    chk("R6 resume from held", int'(cntVal), held + 1);
    runOut();

    // R6 clear coincides with wrap, and clear beats a start
    tick(0, 1, 0);
    for (int i = 0; i < 10; i++) tick(0, 0, 0);
    tick(0, 0, 1);
    chk("R6 clear beats wrap counter", int'(cntVal), 10);
    chk("R6 clear beats wrap update", int'(updFlag), 0);
    tick(1, 1, 1);
    chk("R6 clear beats start", int'(enOut), 0);
    tick(0, 0, 0); tick(0, 1, 0); runOut();

    // R9 fast start, mode 1
    cfgCmp = 6; cfgReload = 12; cfgMode = 1; cfgFast = 1;
    tick(1, 0, 0);
    chk("R9 forced high after trigger", int'(refOut), 1);
    tick(0, 0, 0);
    chk("R9 still forced", int'(refOut), 1);
    runOut();
    // R9 fast start, mode 0
    cfgMode = 0;
    tick(1, 0, 0);
    chk("R9 forced low in mode 0", int'(refOut), 0);
    runOut();

    // R10 software start ignores fast-compare
    cfgMode = 1;
    tick(0, 1, 0); tick(0, 0, 0);
    chk("R10 no force on software start", int'(refOut), 0);
    runOut();

    // R11 coincident trigger and set
    tick(1, 1, 0);
    chk("R11 coincident start forced", int'(refOut), 1);
    runOut();
    tick(0, 0, 0);

    // R8 corner values
    cfgFast = 0; cfgCmp = 0; cfgReload = 5; cfgMode = 0;
    tick(0, 1, 0); runOut();
    cfgMode = 1; cfgCmp = 9;
    tick(0, 1, 0); runOut();
    // R4 reload of zero: one running cycle
    cfgReload = 0; cfgCmp = 1;
    tick(0, 1, 0);
    tick(0, 0, 0);
    chk("R4 reload zero stops", int'(enOut), 0);
    chk("R5 reload zero update", int'(updFlag), 1);
    idle(PIPE + 2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule